// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit Poller

This block is the transmit side of an ATM-layer master on a UTOPIA Level 2 bus. Cells wait in a first-word-fall-through FIFO. The FIFO presents a valid flag, the destination port of the head cell and the current octet. The block drives a 5-bit transmit address bus and reads one cell-available line that all PHY ports share. A PHY answers a poll in the cycle after its address appears, and the block samples that answer at the end of that cycle.

While a cell waits, the block spends every other cycle polling the head cell's own port. It fills the cycles in between with a round-robin sweep over the remaining ports. When the head port reports room, the block drives that port's address for one cycle with transmit enable still high. It then streams the 53 octets with transmit enable low and marks the first octet with start-of-cell. The sweep over the other ports continues during transmission and between cells. This lets outside logic that watches the address bus and the cell-available line follow every port's state. The block also keeps its own per-port bitmap of the last poll results.

A single enable input turns Level 2 transmit operation on. While it is low, the block parks the bus on the null address 5'h1F and does not start a cell.

Top module: `utl2_tx_poller`

## Requirements
- R1: During reset and until the first enabled clock edge, `tx_addr` is 5'h1F, `tx_enb_n` is 1, `tx_soc` is 0, `fifo_rd` is 0 and `port_status` is all zeros.
- R2: After any clock edge at which `mode_en` is 0, `tx_addr` is 5'h1F, and no new cell is started while `mode_en` stays 0, even if a cell waits and its port has room.
- R3: With the FIFO empty and `mode_en` at 1, each cycle polls one port, and the ports follow in increasing order, wrapping from NUM_PORTS-1 back to 0.
- R4: A poll driven in cycle c is answered by `tx_clav` during cycle c+1 and sampled at the end of c+1. Bit p of `port_status` then takes that value, and it changes only through polls of port p.
- R5: While a cell waits and is not being sent, the head cell's port is polled every other cycle. The cycles in between poll the other ports in round-robin order, skipping the head port.
- R6: Transmission starts only after a poll of the head port returned `tx_clav` = 1. While that port reports 0, `tx_enb_n` stays 1 and `fifo_rd` stays 0.
- R7: In the cycle just before `tx_enb_n` falls, `tx_addr` carries the head cell's port and `tx_enb_n` is still 1.
- R8: A cell occupies exactly 53 consecutive cycles with `tx_enb_n` = 0 and `fifo_rd` = 1, with `tx_data` equal to `fifo_data`. `tx_soc` is 1 only in the first of them, and `fifo_rd` is never 1 while `fifo_valid` is 0.
- R9: During transmission the address bus polls other ports only: never the port being sent to and never 5'h1F.
- R10: `tx_addr` is always either 5'h1F or a port number below NUM_PORTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Level 2 transmit operation enable |
| fifo_valid | input | 1 | A cell is at the FIFO head |
| fifo_port | input | PIDX_W | Destination port of the head cell |
| fifo_data | input | DATA_W | Current head octet (fall-through) |
| fifo_rd | output | 1 | Pop one octet |
| tx_addr | output | 5 | Transmit address bus (poll and select) |
| tx_clav | input | 1 | Shared cell-available line from the PHYs |
| tx_enb_n | output | 1 | Transmit enable, active low |
| tx_soc | output | 1 | Start of cell, first octet only |
| tx_data | output | DATA_W | Transmit octet |
| port_status | output | NUM_PORTS | Last sampled cell-available value per port |

## Verification
The bench attacks the two-cycle gap between a poll and its answer with a PHY model that responds one cycle late. A design that sampled `tx_clav` in the wrong cycle would record one port's room under its neighbour and fail the bitmap patterns. A blocked head port is held for many cycles to check both the strict alternation and the fact that the sweep skips the head port; a design that double-polled, forgot to skip, or sent anyway would break the address sequence or pull `tx_enb_n` low. Cells go to ports 0 and 15 to cover the wrap of the sweep and the skip at the ends of the range. The checks cover the selection cycle, the single start-of-cell marker and the 53-octet length. A final case turns the enable off while a sendable cell waits, which catches a design that lets a selection through while disabled.

// File: rtl/utl2_pkg.sv
package utl2_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 5'h1F;
  localparam int CELL_OCTETS = 53;

  typedef enum logic [1:0] {
    ST_POLL   = 2'd0,
    ST_SELECT = 2'd1,
    ST_SEND   = 2'd2
  } tx_state_e;

  // What the address on the bus in a given cycle stands for
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_RR   = 2'd1,
    PK_HEAD = 2'd2,
    PK_SEL  = 2'd3
  } poll_kind_e;
endpackage

// File: rtl/utl2_rr_sched.sv
module utl2_rr_sched #(
  parameter int NUM_PORTS = 16,
  parameter int PIDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              skip_valid,
  input  logic [PIDX_W-1:0] skip_port,
  output logic [PIDX_W-1:0] cand
);
  localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NUM_PORTS - 1);

  logic [PIDX_W-1:0] ptr_q, ptr_d;

  function automatic logic [PIDX_W-1:0] step(input logic [PIDX_W-1:0] x);
    return (x == LAST_PORT) ? '0 : x + 1'b1;
  endfunction

  always_comb begin
    cand  = ptr_q;
    if (skip_valid && (ptr_q == skip_port)) begin
      cand = step(ptr_q);
    end
    ptr_d = ptr_q;
    if (advance) begin
      ptr_d = step(cand);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  // R5: the candidate never lands on the port being skipped
  p_skip_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_valid |-> (cand != skip_port));
endmodule

// File: rtl/utl2_status.sv
module utl2_status #(
  parameter int NUM_PORTS = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic                 clav,
  output logic [NUM_PORTS-1:0] status
);
  logic [NUM_PORTS-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (upd_en && (upd_addr == ADDR_W'(i))) begin
        stat_d[i] = clav;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;

  // R4: without an update the bitmap is frozen
  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(status));
endmodule

// File: rtl/utl2_cell_ctrl.sv
module utl2_cell_ctrl
  import utl2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_select,
  output logic in_poll,
  output logic in_send,
  output logic first_oct
);
  localparam int CNT_W = $clog2(CELL_OCTETS);
  localparam logic [CNT_W-1:0] LAST_OCT = CNT_W'(CELL_OCTETS - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_POLL:   if (go_select) state_d = ST_SELECT;
      ST_SELECT: state_d = ST_SEND;
      ST_SEND: begin
        if (cnt_q == LAST_OCT) begin
          state_d = ST_POLL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default:   state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POLL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign in_poll   = (state_q == ST_POLL);
  assign in_send   = (state_q == ST_SEND);
  assign first_oct = in_send && (cnt_q == '0);

  // R8: a cell is not cut short before its last octet
  p_cell_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && (cnt_q != LAST_OCT)) |=> in_send);

  // R7: a send is always preceded by the selection state
  p_select_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_send) |-> $past(state_q == ST_SELECT));
endmodule

// File: rtl/utl2_tx_poller.sv
module utl2_tx_poller
  import utl2_pkg::*;
#(
  parameter int  NUM_PORTS = 16,
  parameter int  DATA_W    = 8,
  localparam int PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_en,
  input  logic                 fifo_valid,
  input  logic [PIDX_W-1:0]    fifo_port,
  input  logic [DATA_W-1:0]    fifo_data,
  output logic                 fifo_rd,
  output logic [ADDR_W-1:0]    tx_addr,
  input  logic                 tx_clav,
  output logic                 tx_enb_n,
  output logic                 tx_soc,
  output logic [DATA_W-1:0]    tx_data,
  output logic [NUM_PORTS-1:0] port_status
);
  poll_kind_e        cur_kind_q, cur_kind_d, prev_kind_q;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d, prev_addr_q;
  logic              ph_q, ph_d;
  logic              in_poll, in_send, first_oct;
  logic              go_select, rr_adv, upd_en;
  logic [PIDX_W-1:0] rr_cand;
  logic [ADDR_W-1:0] head_addr;

  assign head_addr = ADDR_W'(fifo_port);

  // Answer to the head poll of two edges back arrives now
  assign go_select = in_poll && mode_en && fifo_valid && tx_clav &&
                     (prev_kind_q == PK_HEAD) && (prev_addr_q == head_addr);

  always_comb begin
    cur_kind_d = PK_NONE;
    cur_addr_d = NULL_ADDR;
    ph_d       = 1'b0;
    if (!mode_en) begin
      cur_kind_d = PK_NONE;
    end else if (go_select) begin
      cur_kind_d = PK_SEL;
      cur_addr_d = head_addr;
    end else if (in_poll && fifo_valid && !ph_q) begin
      cur_kind_d = PK_HEAD;
      cur_addr_d = head_addr;
      ph_d       = 1'b1;
    end else begin
      cur_kind_d = PK_RR;
      cur_addr_d = ADDR_W'(rr_cand);
    end
  end

  assign rr_adv = (cur_kind_d == PK_RR);
  assign upd_en = (prev_kind_q == PK_RR) || (prev_kind_q == PK_HEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind_q  <= PK_NONE;
      cur_addr_q  <= NULL_ADDR;
      prev_kind_q <= PK_NONE;
      prev_addr_q <= NULL_ADDR;
      ph_q        <= 1'b0;
    end else begin
      cur_kind_q  <= cur_kind_d;
      cur_addr_q  <= cur_addr_d;
      prev_kind_q <= cur_kind_q;
      prev_addr_q <= cur_addr_q;
      ph_q        <= ph_d;
    end
  end

  utl2_rr_sched #(
    .NUM_PORTS (NUM_PORTS),
    .PIDX_W    (PIDX_W)
  ) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (rr_adv),
    .skip_valid (fifo_valid),
    .skip_port  (fifo_port),
    .cand       (rr_cand)
  );

  utl2_status #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_addr (prev_addr_q),
    .clav     (tx_clav),
    .status   (port_status)
  );

  utl2_cell_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_select (go_select),
    .in_poll   (in_poll),
    .in_send   (in_send),
    .first_oct (first_oct)
  );

  assign tx_addr  = cur_addr_q;
  assign tx_enb_n = !in_send;
  assign tx_soc   = first_oct;
  assign fifo_rd  = in_send;
  assign tx_data  = in_send ? fifo_data : '0;

  // R2: disabled edge parks the bus on the null address
  p_null_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (tx_addr == NULL_ADDR));

  // R7: enable falls only after the head port was put on the bus
  p_select_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enb_n) |-> ($past(tx_addr) == $past(head_addr)));

  // R8: start-of-cell only on the first enabled octet
  p_soc_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> (!tx_enb_n && $past(tx_enb_n)));

  // R8: never pop an empty FIFO
  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_valid);

  // R9: no poll of the destination while its cell is on the bus
  p_no_self_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enb_n && mode_en) |-> (tx_addr != head_addr));

  // R10: address is a real port or null
  p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_addr == NULL_ADDR) || (tx_addr < ADDR_W'(NUM_PORTS)));
endmodule

// File: tb/utl2_tx_poller_tb.sv
module utl2_tx_poller_tb;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic        fifo_valid = 1'b0;
  logic [3:0]  fifo_port = '0;
  logic [7:0]  fifo_data;
  logic        fifo_rd;
  logic [4:0]  tx_addr;
  logic        tx_clav = 1'b0;
  logic        tx_enb_n;
  logic        tx_soc;
  logic [7:0]  tx_data;
  logic [NP-1:0] port_status;

  logic [31:0] room = '0;
  logic [4:0]  a_prev = 5'h1F;
  int          oct = 0;
  int          load_seq = 0;
  int          load_seen = 0;
  logic [3:0]  load_port = '0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  utl2_tx_poller #(.NUM_PORTS(NP), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .fifo_valid(fifo_valid), .fifo_port(fifo_port), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .tx_addr(tx_addr), .tx_clav(tx_clav),
    .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
    .port_status(port_status)
  );

  function automatic logic [7:0] pat(input int p, input int k);
    return 8'((p << 4) ^ k ^ 8'h5A);
  endfunction

  assign fifo_data = pat(int'(fifo_port), oct);

  // PHY model: answers in the cycle after the address appears
  always @(negedge clk) begin
    tx_clav = room[a_prev];
    a_prev  = tx_addr;
  end

  // Single-cell FIFO model
  always @(posedge clk) begin
    if (load_seq != load_seen) begin
      load_seen  <= load_seq;
      fifo_valid <= 1'b1;
      fifo_port  <= load_port;
      oct        <= 0;
    end else if (fifo_rd) begin
      if (oct == 52) begin
        fifo_valid <= 1'b0;
        oct        <= 0;
      end else begin
        oct <= oct + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int p);
    load_port = 4'(p);
    load_seq++;
  endtask

  function automatic int nxt(input int x, input int skip);
    int n = (x + 1) % NP;
    if (n == skip) n = (n + 1) % NP;
    return n;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_addr == 5'h1F, "R1", "addr in reset", tx_addr, 31);
    chk(tx_enb_n == 1'b1 && tx_soc == 1'b0 && fifo_rd == 1'b0, "R1",
        "enb/soc/rd in reset", {tx_enb_n, tx_soc, fifo_rd}, 4);
    chk(port_status == '0, "R1", "status in reset", port_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    int bad = 0;
    mode_en = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (tx_addr != 5'h1F || !tx_enb_n || fifo_rd) bad++;
    end
    chk(bad == 0, "R2", "null bus while disabled", bad, 0);
  endtask

  task automatic t_rr();
    int a0, bad = 0;
    mode_en = 1'b1;
    repeat (3) @(negedge clk);
    a0 = int'(tx_addr);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (int'(tx_addr) != (a0 + 1) % NP) bad++;
      a0 = int'(tx_addr);
    end
    chk(bad == 0, "R3", "round-robin order with wrap", bad, 0);
  endtask

  task automatic t_status(input logic [NP-1:0] pattern);
    room[NP-1:0] = pattern;
    repeat (2 * NP + 4) @(negedge clk);
    chk(port_status == pattern, "R4", "status bitmap", port_status, pattern);
  endtask

  task automatic t_blocked(input int p);
    int a[24];
    int alt_bad = 0, rr_bad = 0, enb_bad = 0, last = -1;
    room[p] = 1'b0;
    load(p);
    repeat (4) @(negedge clk);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      a[c] = int'(tx_addr);
      if (!tx_enb_n || fifo_rd) enb_bad++;
    end
    for (int c = 1; c < 24; c++) begin
      if ((a[c] == p) == (a[c-1] == p)) alt_bad++;
    end
    for (int c = 0; c < 24; c++) begin
      if (a[c] != p) begin
        if (last >= 0 && a[c] != nxt(last, p)) rr_bad++;
        last = a[c];
      end
    end
    chk(alt_bad == 0, "R5", "head poll alternation", alt_bad, 0);
    chk(rr_bad == 0, "R5", "sweep skips head port", rr_bad, 0);
    chk(enb_bad == 0, "R6", "no send while head port full", enb_bad, 0);
    chk(port_status[p] == 1'b0, "R4", "head port status 0", port_status[p], 0);
  endtask

  task automatic t_send(input int p);
    int k = 0;
    bit seen = 0, sel_ok = 0;
    int soc_bad = 0, dat_bad = 0, adr_bad = 0;
    logic [4:0] pa = 5'h1F;
    logic pe = 1'b1;
    room[p] = 1'b1;
    if (!fifo_valid) load(p);
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (!tx_enb_n) begin
        if (!seen) begin
          seen = 1;
          sel_ok = pe && (int'(pa) == p);
        end
        if (tx_soc != (k == 0)) soc_bad++;
        if (tx_data != pat(p, k) || !fifo_rd) dat_bad++;
        if (int'(tx_addr) == p || tx_addr == 5'h1F) adr_bad++;
        k++;
      end else begin
        if (tx_soc) soc_bad++;
        if (seen) break;
      end
      pa = tx_addr;
      pe = tx_enb_n;
    end
    chk(seen, "R6", "cell started once port has room", seen, 1);
    chk(sel_ok, "R7", "select cycle address", pa, p);
    chk(k == 53, "R8", "cell length", k, 53);
    chk(soc_bad == 0 && dat_bad == 0, "R8", "soc and data", soc_bad + dat_bad, 0);
    chk(adr_bad == 0, "R9", "other ports polled during send", adr_bad, 0);
    chk(fifo_valid == 1'b0, "R8", "cell fully popped", fifo_valid, 0);
  endtask

  task automatic t_disable_pending(input int p);
    int bad = 0;
    mode_en = 1'b0;
    room[p] = 1'b1;
    load(p);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!tx_enb_n || tx_addr != 5'h1F) bad++;
    end
    chk(bad == 0 && fifo_valid, "R2", "no start while disabled", bad, 0);
    mode_en = 1'b1;
    t_send(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_disabled();
    t_rr();
    t_status(16'hA5C3);
    t_status(16'h5A3C);
    t_blocked(5);
    t_send(5);
    t_send(0);
    t_send(15);
    t_blocked(15);
    t_send(15);
    t_disable_pending(9);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule